// File: doc/BRIEF.md
# Auto-Increment Register Loader with Hex Address Display

This block is the front end of a small register file that is programmed from push buttons and switches. An 8-bit data value is set on the data input. A rising edge on the load button writes that value to the current address and then moves the address on by one. The skip button moves the address on without writing. The zero control sends the address back to 0.

The write goes out as a one-cycle strobe together with the address and the data, and the register file sits outside this block. The address that the next write will use always shows on a seven-segment digit as a hexadecimal character. None of the button inputs are debounced. Every control passes through a synchronizer, and load and skip act only on their rising edges, so holding a button down gives a single action.

Top module: `regld_loader`

## Requirements
- R1: While reset is high and on the first cycle after it, the address is 0, the write strobe is low and the display shows the digit 0.
- R2: A rising edge on load raises the write strobe for exactly one cycle, with the write address equal to the current address and the write data equal to the data input. On the next cycle the address is one higher.
- R3: Holding load high for many cycles produces exactly one write. A new write needs load to go low and then high again.
- R4: A rising edge on skip increases the address by one and raises no write strobe.
- R5: While zero is high the address is 0. Load and skip edges that arrive during that time neither write nor advance.
- R6: If zero and a load rising edge reach the logic in the same cycle, zero wins. No write occurs and the address is 0.
- R7: The address wraps from 15 to 0 on load or on skip. A load at address 15 writes address 15.
- R8: If load and skip rise in the same cycle, exactly one write happens at the current address and the address advances by exactly one.
- R9: The display is active high with bit 0 = segment a through bit 6 = segment g. It shows the hexadecimal address with the patterns 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71. The decimal point output stays 0.
- R10: Each control passes through a two-flop synchronizer. A load that goes high before a clock edge raises the strobe only after the second rising edge, and the strobe is still low after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| data_i | input | 8 | Byte to be written |
| load_i | input | 1 | Load button, asynchronous, rising-edge acting |
| skip_i | input | 1 | Skip button, asynchronous, rising-edge acting |
| zero_i | input | 1 | Address-to-zero control, asynchronous, level acting |
| wr_en_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 4 | Current address, also the write address |
| wr_data_o | output | 8 | Write data |
| seg_o | output | 7 | Segments a..g (bit 0 = a) |
| seg_dp_o | output | 1 | Decimal point, always off |

## Verification
The assertions assume that reset is high on the first clock edge. They also assume that zero is never high in a cycle that raises the strobe, since that case has to suppress the write. The data input is assumed to stay stable while load is high, because the byte is not synchronized. The bench drives every input on the falling clock edge. It holds each data byte for the whole of a press, and it keeps each button level for several cycles so that every edge crosses the synchronizer cleanly.

// File: rtl/regld_pkg.sv
package regld_pkg;
   localparam int SEG_W = 7;

   function automatic logic [SEG_W-1:0] hex_glyph(input logic [3:0] nib);
      logic [SEG_W-1:0] g;
      unique case (nib)
         4'h0: g = 7'h3F;
         4'h1: g = 7'h06;
         4'h2: g = 7'h5B;
         4'h3: g = 7'h4F;
         4'h4: g = 7'h66;
         4'h5: g = 7'h6D;
         4'h6: g = 7'h7D;
         4'h7: g = 7'h07;
         4'h8: g = 7'h7F;
         4'h9: g = 7'h6F;
         4'hA: g = 7'h77;
         4'hB: g = 7'h7C;
         4'hC: g = 7'h39;
         4'hD: g = 7'h5E;
         4'hE: g = 7'h79;
         default: g = 7'h71;
      endcase
      return g;
   endfunction
endpackage

// File: rtl/regld_sync.sv
module regld_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      initial $error("regld_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      initial $error("regld_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/regld_rise.sv
module regld_rise #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise
);
   logic [W-1:0] lvl_q;

   always_ff @(posedge clk) begin
      if (rst) lvl_q <= '0;
      else     lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/regld_addr_ctr.sv
module regld_addr_ctr #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr
);
   if (ADDR_W < 1) begin : g_bad_addr
      initial $error("regld_addr_ctr: ADDR_W must be at least 1");
   end

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

   always_ff @(posedge clk) begin
      if (rst || clr) addr <= '0;
      else if (inc)   addr <= addr + STEP;
   end
endmodule

// File: rtl/regld_seg7.sv
module regld_seg7 #(
   parameter int ADDR_W         = 4,
   parameter bit SEG_ACTIVE_LOW = 1'b0
) (
   input  logic [ADDR_W-1:0]          val,
   output logic [regld_pkg::SEG_W-1:0] seg,
   output logic                        dp
);
   import regld_pkg::*;

   if (ADDR_W > 4) begin : g_bad_disp
      initial $error("regld_seg7: one digit shows at most 4 address bits");
   end

   logic [3:0]       nib;
   logic [SEG_W-1:0] glyph;

   if (ADDR_W == 4) begin : g_full
      assign nib = val;
   end else begin : g_pad
      assign nib = {{(4-ADDR_W){1'b0}}, val};
   end

   assign glyph = hex_glyph(nib);

   if (SEG_ACTIVE_LOW) begin : g_low
      assign seg = ~glyph;
      assign dp  = 1'b1;
   end else begin : g_high
      assign seg = glyph;
      assign dp  = 1'b0;
   end
endmodule

// File: rtl/regld_loader.sv
module regld_loader #(
   parameter int DATA_W         = 8,
   parameter int ADDR_W         = 4,
   parameter int SYNC_STAGES    = 2,
   parameter bit SEG_ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] data_i,
   input  logic              load_i,
   input  logic              skip_i,
   input  logic              zero_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [6:0]        seg_o,
   output logic              seg_dp_o
);
   localparam int N_CTL  = 3;
   localparam int I_LOAD = 0;
   localparam int I_SKIP = 1;
   localparam int I_ZERO = 2;

   if (DATA_W < 1) begin : g_bad_data
      initial $error("regld_loader: DATA_W must be at least 1");
   end

   logic [N_CTL-1:0] ctl_s;
   logic [1:0]       btn_rise;
   logic             load_rise, skip_rise, zero_s, advance;

   regld_sync #(.W(N_CTL), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({zero_i, skip_i, load_i}),
      .q   (ctl_s)
   );

   regld_rise #(.W(2)) u_rise (
      .clk  (clk),
      .rst  (rst),
      .lvl  ({ctl_s[I_SKIP], ctl_s[I_LOAD]}),
      .rise (btn_rise)
   );

   assign load_rise = btn_rise[0];
   assign skip_rise = btn_rise[1];
   assign zero_s    = ctl_s[I_ZERO];
   assign advance   = load_rise | skip_rise;

   regld_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .clr  (zero_s),
      .inc  (advance),
      .addr (wr_addr_o)
   );

   assign wr_en_o   = load_rise & ~zero_s;
   assign wr_data_o = data_i;

   regld_seg7 #(.ADDR_W(ADDR_W), .SEG_ACTIVE_LOW(SEG_ACTIVE_LOW)) u_seg (
      .val (wr_addr_o),
      .seg (seg_o),
      .dp  (seg_dp_o)
   );
endmodule

// File: rtl/regld_loader_chk.sv
module regld_loader_chk #(
   parameter int ADDR_W         = 4,
   parameter bit SEG_ACTIVE_LOW = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic [6:0]        seg_o
);
   // R1: reset leaves the address at zero and no strobe
   p_reset_home_r1: assert property (@(posedge clk)
      rst |=> (wr_addr_o == '0 && !wr_en_o));

   // R2, R3: the strobe never lasts two cycles
   p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
      wr_en_o |=> !wr_en_o);

   // R2: after a write the address has moved on (or zero took it home)
   p_advance_after_write_r2: assert property (@(posedge clk) disable iff (rst)
      wr_en_o |=> (wr_addr_o == ADDR_W'($past(wr_addr_o) + 1'b1) || wr_addr_o == '0));

   // R7: the address only steps by one (wrapping) or returns to zero
   p_addr_steps_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_addr_o != $past(wr_addr_o)) |->
         (wr_addr_o == ADDR_W'($past(wr_addr_o) + 1'b1) || wr_addr_o == '0));

   // R9: every hex glyph lights at least two segments
   p_seg_lit_r9: assert property (@(posedge clk) disable iff (rst)
      $countones(SEG_ACTIVE_LOW ? ~seg_o : seg_o) >= 2);
endmodule

bind regld_loader regld_loader_chk #(.ADDR_W(ADDR_W), .SEG_ACTIVE_LOW(SEG_ACTIVE_LOW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .wr_en_o   (wr_en_o),
   .wr_addr_o (wr_addr_o),
   .seg_o     (seg_o)
);

// File: tb/regld_loader_tb.sv
module regld_loader_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] data_i = '0;
   logic       load_i = 1'b0, skip_i = 1'b0, zero_i = 1'b0;
   logic       wr_en_o;
   logic [3:0] wr_addr_o;
   logic [7:0] wr_data_o;
   logic [6:0] seg_o;
   logic       seg_dp_o;

   int errors = 0;
   int checks = 0;
   int n_wr = 0;
   logic [3:0] last_wa = '0;
   logic [7:0] last_wd = '0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   regld_loader dut_i (
      .clk(clk), .rst(rst), .data_i(data_i), .load_i(load_i), .skip_i(skip_i),
      .zero_i(zero_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o), .seg_o(seg_o), .seg_dp_o(seg_dp_o)
   );

   always @(negedge clk) begin
      if (!rst && wr_en_o) begin
         n_wr++;
         last_wa = wr_addr_o;
         last_wd = wr_data_o;
      end
   end

   function automatic logic [6:0] want_seg(input logic [3:0] v);
      logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                            7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
      return t[v];
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic press(input bit ld, input bit sk, input bit zr, input logic [7:0] d);
      data_i = d;
      load_i = ld; skip_i = sk; zero_i = zr;
      cyc(4);
      load_i = 1'b0; skip_i = 1'b0; zero_i = 1'b0;
      cyc(4);
   endtask

   task automatic t_reset;
      cyc(1);
      chk(wr_addr_o == 4'd0, "R1 addr", wr_addr_o, 0);
      chk(!wr_en_o, "R1 strobe", wr_en_o, 0);
      chk(seg_o == 7'h3F, "R1 display", seg_o, 7'h3F);
      chk(!seg_dp_o, "R9 dp", seg_dp_o, 0);
   endtask

   task automatic t_latency_load;
      int w0;
      w0 = n_wr;
      data_i = 8'hA5;
      load_i = 1'b1;
      cyc(1);
      chk(!wr_en_o, "R10 strobe low after one edge", wr_en_o, 0);
      @(negedge clk);
      chk(wr_en_o, "R10 strobe after two edges", wr_en_o, 1);
      chk(wr_addr_o == 4'd0, "R2 write addr", wr_addr_o, 0);
      chk(wr_data_o == 8'hA5, "R2 write data", wr_data_o, 8'hA5);
      @(negedge clk);
      chk(!wr_en_o, "R2 strobe one cycle", wr_en_o, 0);
      chk(wr_addr_o == 4'd1, "R2 addr advanced", wr_addr_o, 1);
      cyc(10);
      chk(n_wr - w0 == 1, "R3 held load writes once", n_wr - w0, 1);
      chk(wr_addr_o == 4'd1, "R3 addr holds", wr_addr_o, 1);
      load_i = 1'b0;
      cyc(4);
      press(1, 0, 0, 8'h5A);
      chk(n_wr - w0 == 2 && last_wa == 4'd1 && last_wd == 8'h5A, "R3 re-press writes",
          {last_wa, last_wd}, {4'd1, 8'h5A});
   endtask

   task automatic t_skip;
      int w0;
      logic [3:0] a0;
      w0 = n_wr; a0 = wr_addr_o;
      press(0, 1, 0, 8'hFF);
      chk(wr_addr_o == a0 + 4'd1, "R4 skip advances", wr_addr_o, a0 + 4'd1);
      chk(n_wr == w0, "R4 skip no write", n_wr - w0, 0);
   endtask

   task automatic t_zero;
      int w0;
      press(0, 0, 1, 8'h00);
      chk(wr_addr_o == 4'd0, "R5 zero returns home", wr_addr_o, 0);
      press(0, 1, 0, 8'h00);
      press(0, 1, 0, 8'h00);
      w0 = n_wr;
      zero_i = 1'b1;
      cyc(4);
      chk(wr_addr_o == 4'd0, "R5 zero held", wr_addr_o, 0);
      load_i = 1'b1; skip_i = 1'b0;
      cyc(4);
      load_i = 1'b0;
      cyc(2);
      skip_i = 1'b1;
      cyc(4);
      chk(n_wr == w0, "R5 load ignored under zero", n_wr - w0, 0);
      chk(wr_addr_o == 4'd0, "R5 no advance under zero", wr_addr_o, 0);
      zero_i = 1'b0; skip_i = 1'b0;
      cyc(4);
   endtask

   task automatic t_zero_vs_load;
      int w0;
      press(0, 1, 0, 8'h00);
      press(0, 1, 0, 8'h00);
      press(0, 1, 0, 8'h00);
      w0 = n_wr;
      press(1, 0, 1, 8'h77);
      chk(n_wr == w0, "R6 zero wins no write", n_wr - w0, 0);
      chk(wr_addr_o == 4'd0, "R6 zero wins addr", wr_addr_o, 0);
   endtask

   task automatic t_both;
      int w0;
      logic [3:0] a0;
      press(0, 1, 0, 8'h00);
      w0 = n_wr; a0 = wr_addr_o;
      press(1, 1, 0, 8'hC3);
      chk(n_wr - w0 == 1 && last_wa == a0 && last_wd == 8'hC3, "R8 single write",
          n_wr - w0, 1);
      chk(wr_addr_o == a0 + 4'd1, "R8 single advance", wr_addr_o, a0 + 4'd1);
   endtask

   task automatic t_display_wrap;
      int w0;
      press(0, 0, 1, 8'h00);
      for (int i = 0; i < 16; i++) begin
         chk(seg_o == want_seg(4'(i)), "R9 glyph", seg_o, want_seg(4'(i)));
         chk(!seg_dp_o, "R9 dp off", seg_dp_o, 0);
         if (i < 15) press(0, 1, 0, 8'h00);
      end
      chk(wr_addr_o == 4'hF, "R7 reached 15", wr_addr_o, 15);
      w0 = n_wr;
      press(1, 0, 0, 8'h3C);
      chk(n_wr - w0 == 1 && last_wa == 4'hF && last_wd == 8'h3C, "R7 write at 15",
          last_wa, 15);
      chk(wr_addr_o == 4'd0, "R7 load wraps", wr_addr_o, 0);
      press(0, 0, 1, 8'h00);
      for (int i = 0; i < 16; i++) press(0, 1, 0, 8'h00);
      chk(wr_addr_o == 4'd0, "R7 skip wraps", wr_addr_o, 0);
   endtask

   initial begin
      cyc(3);
      rst = 1'b0;
      t_reset;
      t_latency_load;
      t_skip;
      t_zero;
      t_zero_vs_load;
      t_both;
      t_display_wrap;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule